// File: doc/BRIEF.md
# Chip-Select-Gated Address Register

This block is the registered buffer that sits between a memory controller and the DRAM devices on a memory module. It carries the address and command lines. Every output is a flip-flop that loads on the rising clock edge. Two static configuration inputs choose how the outputs are arranged:

- **Wide mode:** one input per output.
- **Split mode:** fewer inputs, each driven onto two output copies. A second configuration bit picks one of two lane layouts for split mode.

Two active-low select inputs gate the general data outputs. When both selects are high, those outputs hold their previous value. The chip-select, clock-enable and termination outputs keep updating. An asynchronous active-low reset clears every output at once, without waiting for a clock edge.

The output bus is laid out as follows:

- **Wide mode:** output bit i follows input bit i for i in 0..24. Output 25 carries the registered primary select. Outputs 26..29 are zero.
- **Split mode:** there are 15 lanes. Lane j appears on output j (copy A) and on output 15+j (copy B).

Top module: `csgate_addr_reg`

## Requirements
- R1: With cfgSplit=0 and a select low, each rising edge loads qOut[22:0] from dataIn[22:0].
- R2: With cfgSplit=0, the control outputs load on every rising edge, whatever the selects are. The control outputs are qOut[23] (clock enable, from dataIn[23]), qOut[24] (termination, from dataIn[24]) and qOut[25] (from csPrimN). qOut[29:26] stay 0.
- R3: With cfgSplit=1 and cfgLayoutB=0, lane j (j<14) takes dataIn[j] and lane 14 takes csPrimN. Lane j drives both qOut[j] and qOut[15+j].
- R4: With cfgSplit=1 and cfgLayoutB=1, lane 0 takes csPrimN and lane j (1..14) takes dataIn[j-1]. Each lane drives both of its copies.
- R5: When csPrimN and csAuxN are both 1 at a rising edge, every non-control output keeps its value.
- R6: If either select is 0 at a rising edge, all outputs update. This includes csAuxN low alone, which is the case of the auxiliary select tied low.
- R7: In split mode the control lanes update even while gated. These are lanes 12, 13 and 14 in layout A, and lanes 0, 1 and 2 in layout B.
- R8: A low rstN forces qOut to all zeros immediately, without a clock edge.
- R9: After rstN rises, qOut stays zero until the first rising clock edge.
- R10: In split mode, dataIn[24:14] have no effect on qOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 25 | Address/command inputs |
| csPrimN | input | 1 | Primary active-low select, also registered as a control output |
| csAuxN | input | 1 | Auxiliary active-low select (gating only) |
| cfgSplit | input | 1 | 0: wide one-to-one mode, 1: split one-to-two mode |
| cfgLayoutB | input | 1 | Split-mode lane layout: 0 = A, 1 = B |
| qOut | output | 30 | Registered outputs |

## Verification
On every cycle, the assertions check the following:

- wide-mode data transfer under an active select;
- holding of the data bits while gated;
- registration of the select lane in each layout;
- equality of the two copies in split mode;
- zero outputs during and just after reset.

Only the bench's scenarios can show the rest:

- the exact lane mapping of both split layouts;
- that the control lanes keep updating while the data lanes are frozen;
- that the upper inputs are ignored in split mode;
- the immediate clearing of the outputs when reset falls in the middle of a cycle.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
  typedef struct packed {
    logic split;    // one-to-two fan-out
    logic layoutB;  // split lane layout select
    logic hold;     // freeze non-control outputs
  } csgStrobe_t;

  function automatic int outWidth(int wide, int narrow);
    return (wide + 1 > 2 * (narrow + 1)) ? wide + 1 : 2 * (narrow + 1);
  endfunction
endpackage

// File: rtl/csg_ctrl.sv
`timescale 1ns/1ps
module csg_ctrl
  import csg_pkg::*;
(
  input  logic       csPrimN,
  input  logic       csAuxN,
  input  logic       cfgSplit,
  input  logic       cfgLayoutB,
  output csgStrobe_t strobe
);
  always_comb begin
    strobe.split   = cfgSplit;
    strobe.layoutB = cfgSplit & cfgLayoutB;
    strobe.hold    = csPrimN & csAuxN;
  end
endmodule

// File: rtl/csg_path.sv
`timescale 1ns/1ps
module csg_path
  import csg_pkg::*;
#(
  parameter int WIDE   = 25,
  parameter int NARROW = 14,
  localparam int LANES = NARROW + 1,
  localparam int OUT_W = outWidth(WIDE, NARROW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDE-1:0]  dataIn,
  input  logic             csPrimN,
  input  csgStrobe_t       strobe,
  output logic [OUT_W-1:0] qOut
);
  logic [LANES-1:0] lane, laneCtrl;
  logic [OUT_W-1:0] mapped, ctrlMask, qReg;

  // Routing of inputs to output positions, plus which positions are never gated
  always_comb begin
    lane     = '0;
    laneCtrl = '0;
    mapped   = '0;
    ctrlMask = '0;
    if (!strobe.split) begin
      mapped[WIDE-1:0]      = dataIn;
      mapped[WIDE]          = csPrimN;
      ctrlMask[WIDE:WIDE-2] = '1;
    end else begin
      if (!strobe.layoutB) begin
        lane[NARROW-1:0]            = dataIn[NARROW-1:0];
        lane[NARROW]                = csPrimN;
        laneCtrl[NARROW:NARROW-2]   = '1;
      end else begin
        lane          = {dataIn[NARROW-1:0], csPrimN};
        laneCtrl[2:0] = '1;
      end
      mapped[LANES-1:0]         = lane;
      mapped[2*LANES-1:LANES]   = lane;
      ctrlMask[LANES-1:0]       = laneCtrl;
      ctrlMask[2*LANES-1:LANES] = laneCtrl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg <= '0;
    end else begin
      for (int b = 0; b < OUT_W; b++) begin
        if (!strobe.hold || ctrlMask[b]) qReg[b] <= mapped[b];
      end
    end
  end

  assign qOut = qReg;
endmodule

// File: rtl/csgate_addr_reg.sv
`timescale 1ns/1ps
module csgate_addr_reg
  import csg_pkg::*;
#(
  parameter int WIDE   = 25,
  parameter int NARROW = 14,
  localparam int OUT_W = outWidth(WIDE, NARROW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDE-1:0]  dataIn,
  input  logic             csPrimN,
  input  logic             csAuxN,
  input  logic             cfgSplit,
  input  logic             cfgLayoutB,
  output logic [OUT_W-1:0] qOut
);
  csgStrobe_t strobe;

  csg_ctrl uCtrl (
    .csPrimN   (csPrimN),
    .csAuxN    (csAuxN),
    .cfgSplit  (cfgSplit),
    .cfgLayoutB(cfgLayoutB),
    .strobe    (strobe)
  );

  csg_path #(.WIDE(WIDE), .NARROW(NARROW)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .csPrimN(csPrimN),
    .strobe (strobe),
    .qOut   (qOut)
  );
endmodule

// File: rtl/csgate_addr_reg_chk.sv
`timescale 1ns/1ps
module csgate_addr_reg_chk #(
  parameter int WIDE   = 25,
  parameter int NARROW = 14,
  localparam int LANES = NARROW + 1,
  localparam int OUT_W = csg_pkg::outWidth(WIDE, NARROW)
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDE-1:0]  dataIn,
  input logic             csPrimN,
  input logic             csAuxN,
  input logic             cfgSplit,
  input logic             cfgLayoutB,
  input logic [OUT_W-1:0] qOut
);
  // R1
  wide_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSplit && !csPrimN) |=> qOut[WIDE-3:0] == $past(dataIn[WIDE-3:0]));
  // R6
  aux_only_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSplit && !csAuxN) |=> qOut[WIDE-3:0] == $past(dataIn[WIDE-3:0]));
  // R2
  wide_cs_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSplit |=> qOut[WIDE] == $past(csPrimN));
  // R5
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSplit && csPrimN && csAuxN) |=> $stable(qOut[WIDE-3:0]));
  // R5
  split_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSplit && !cfgLayoutB && csPrimN && csAuxN) |=> $stable(qOut[NARROW-3:0]));
  // R3
  split_copies_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgSplit |-> qOut[LANES-1:0] == qOut[2*LANES-1:LANES]);
  // R7
  layout_a_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSplit && !cfgLayoutB) |=> qOut[NARROW] == $past(csPrimN));
  // R4
  layout_b_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSplit && cfgLayoutB) |=> qOut[0] == $past(csPrimN));
  // R8
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> qOut == '0);
  // R9
  release_zero_chk: assert property (@(posedge clk) $rose(rstN) |-> qOut == '0);
endmodule

bind csgate_addr_reg csgate_addr_reg_chk #(.WIDE(WIDE), .NARROW(NARROW)) uChk (.*);

// File: tb/sim_csgate_addr_reg.sv
`timescale 1ns/1ps
module sim_csgate_addr_reg;
  localparam int W  = 25;
  localparam int N  = 14;
  localparam int L  = N + 1;
  localparam int OW = 30;

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic csPrimN = 1'b1, csAuxN = 1'b1, cfgSplit = 1'b0, cfgLayoutB = 1'b0;
  logic [OW-1:0] qOut, expQ;
  int errs = 0, checks = 0;

  csgate_addr_reg u0 (.*);

  always #2.5 clk = ~clk;

  // Source value for output bit b, from the requirement text
  function automatic logic srcBit(int b);
    int j;
    if (!cfgSplit) return (b < W) ? dataIn[b] : (b == W) ? csPrimN : 1'b0;
    j = b % L;
    if (cfgLayoutB) return (j == 0) ? csPrimN : dataIn[j-1];
    return (j == N) ? csPrimN : dataIn[j];
  endfunction

  function automatic bit isCtrl(int b);
    int j = b % L;
    if (!cfgSplit) return (b >= W - 2 && b <= W);
    return cfgLayoutB ? (j <= 2) : (j >= N - 2);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) expQ = '0;
    else for (int b = 0; b < OW; b++)
      if (!(csPrimN && csAuxN) || isCtrl(b)) expQ[b] = srcBit(b);
  end

  task automatic chk(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: qOut=%h expected=%h", req, act, exp);
    end
  endtask

  // pat: 0 primary low, 1 auxiliary low only, 2 both high, 3 random
  task automatic run(string req, int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, qOut, expQ);
      dataIn = W'($urandom());
      case (pat)
        0: begin csPrimN = 1'b0; csAuxN = 1'($urandom()); end
        1: begin csPrimN = 1'b1; csAuxN = 1'b0; end
        2: begin csPrimN = 1'b1; csAuxN = 1'b1; end
        default: begin csPrimN = 1'($urandom()); csAuxN = 1'($urandom()); end
      endcase
    end
  endtask

  task automatic restart(logic split, logic layB);
    @(negedge clk);
    rstN = 1'b0;
    #0.5 chk("R8", qOut, '0);
    cfgSplit = split;
    cfgLayoutB = layB;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    dataIn = '1;
    csPrimN = 1'b0;
    #2.0 chk("R9", qOut, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", qOut, '0);
    restart(1'b0, 1'b0);
    run("R1", 20, 0);
    run("R6", 10, 1);
    run("R5", 10, 2);
    run("R2", 20, 3);
    // reset asserted in the middle of a cycle
    @(posedge clk);
    #1 rstN = 1'b0;
    #0.5 chk("R8", qOut, '0);
    restart(1'b1, 1'b0);
    run("R3", 20, 0);
    run("R7", 10, 2);
    run("R10", 20, 3);
    restart(1'b1, 1'b1);
    run("R4", 20, 0);
    run("R7", 10, 2);
    run("R10", 20, 3);
    @(negedge clk);
    chk("R4", qOut, expQ);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: qOut=%h expected=finish", qOut);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule